// File: doc/BRIEF.md
# Camera Frame Capture SRAM Controller

This block sits between a CMOS colour camera and one external single-port asynchronous SRAM that a host processor also uses. It watches the camera's pixel clock, line-valid and frame-sync signals and the 8-bit pixel bus. It stores one complete frame into the SRAM at consecutive addresses starting from zero, and it generates the address, data and an active-low write strobe itself. When the frame ends, it takes its drivers off the SRAM pins, waits one idle cycle, grants the bus to the host and raises a ready flag. While the flag is high, a count of the pixels that were stored is also available.

The host reads the memory at its own pace. It then pulses a release input, which returns the bus to the capture side after another idle cycle. Frame-sync edges that arrive while the host owns the bus are ignored, so a new capture needs a fresh frame-sync edge after the release. A mode input chooses between storing pixels unchanged and storing them binarised against a threshold. The mode is sampled once at the start of each frame.

All camera inputs are sampled in the system clock domain through two-flop synchronisers. The camera pixel clock period must therefore be at least four system clock periods. Pixel data must stay stable from half a pixel-clock period before the rising edge until the following falling edge.

Top module: `frame_capture_sram`

## Requirements
- R1: After reset the capture side owns the bus (capOe=1), hostGrant=0, frameReady=0, sramWeN=1 and pixelCount=0.
- R2: While the block owns the bus and no frame is in progress, a rising edge of camVsync starts a frame. The first stored pixel goes to address 0 and each further stored pixel to the next address. Pixels offered before that edge are not written.
- R3: Inside a frame, a pixel is stored only when camHref is high at a rising edge of camPclk. Pixel clocks with camHref low cause no write.
- R4: For each write, sramAddr and sramData hold their write values in the clock cycle before sramWeN falls. sramWeN stays low for exactly one clock cycle, and the values are unchanged in the cycle when it rises again.
- R5: The next rising edge of camVsync ends the frame. Then follows one clock cycle in which capOe and hostGrant are both 0, after which hostGrant and frameReady are both 1.
- R6: capOe and hostGrant are never high together, and sramWeN is low only while capOe is high.
- R7: While frameReady is high, pixelCount equals the number of pixels stored in the frame just captured, including short frames.
- R8: While the host owns the bus, camVsync edges and pixels have no effect. A one-cycle pulse on hostRelease clears frameReady and hostGrant, leaves one cycle with neither side driving, then sets capOe. Pixels that follow without a new camVsync rising edge are not written.
- R9: With binarize=0, pixels are stored unchanged. With binarize=1, a pixel at or above THRESH (default 128) is stored as 8'hFF and any other pixel as 8'h00. The mode is taken at the camVsync edge that starts the frame, and changes during the frame have no effect.
- R10: Once MAX_PIXELS pixels have been stored in a frame, further pixels are dropped and pixelCount stays at MAX_PIXELS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| camPclk | input | 1 | Camera pixel clock, sampled |
| camHref | input | 1 | Camera line-valid strobe |
| camVsync | input | 1 | Camera frame sync |
| camPix | input | PW | Camera pixel data |
| binarize | input | 1 | 1: store thresholded pixels, 0: store raw pixels |
| hostRelease | input | 1 | Host pulse returning the bus to capture |
| sramAddr | output | AW | SRAM address during capture |
| sramData | output | PW | SRAM write data during capture |
| sramWeN | output | 1 | SRAM write strobe, active low |
| capOe | output | 1 | Enable for the capture-side SRAM pin drivers |
| hostGrant | output | 1 | Host may drive the SRAM bus |
| frameReady | output | 1 | A complete frame is in SRAM for the host |
| pixelCount | output | AW+1 | Pixels stored in the last frame |

## Verification
The assertions check the properties that hold on every clock. The two ownership flags are never high together. The write strobe is only active while the capture side drives the bus. Address and data are stable on both sides of each strobe, and each handover passes through a cycle with no driver. The pixel count never exceeds its limit. The bench scenarios are needed for the properties that depend on frame history: which pixels land at which address, frame-sync edges being ignored during host ownership, the mode being latched at frame start, saturation at the pixel limit, and the reported count for full and short frames.

// File: rtl/frame_cap_pkg.sv
package frame_cap_pkg;

  typedef enum logic [2:0] {
    ST_ARM,
    ST_CAP,
    ST_GAP_H,
    ST_HOST,
    ST_GAP_C
  } capState_e;

  typedef struct packed {
    logic clearAddr;
    logic latchMode;
    logic loadPix;
    logic weLow;
    logic advance;
  } dpCtrl_t;

endpackage

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import frame_cap_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    camPclk,
  input  logic    camHref,
  input  logic    camVsync,
  input  logic    hostRelease,
  input  logic    full,
  output dpCtrl_t ctrl,
  output logic    capOe,
  output logic    hostGrant,
  output logic    frameReady
);

  logic [2:0] pclkSh;
  logic [1:0] hrefSh;
  logic [2:0] vsSh;
  capState_e  state, nextState;
  logic [1:0] phase, nextPhase;
  logic       pclkRise, vsRise, startWr;

  assign pclkRise = pclkSh[1] & ~pclkSh[2];
  assign vsRise   = vsSh[1] & ~vsSh[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      pclkSh <= '0;
      hrefSh <= '0;
      vsSh   <= '0;
      state  <= ST_ARM;
      phase  <= '0;
    end else begin
      pclkSh <= {pclkSh[1:0], camPclk};
      hrefSh <= {hrefSh[0], camHref};
      vsSh   <= {vsSh[1:0], camVsync};
      state  <= nextState;
      phase  <= nextPhase;
    end
  end

  // a write begins only when no frame end is pending on the same cycle
  assign startWr = (state == ST_CAP) && (phase == 2'd0) && !vsRise &&
                   pclkRise && hrefSh[1] && !full;

  always_comb begin
    nextState = state;
    case (state)
      ST_ARM:   if (vsRise) nextState = ST_CAP;
      ST_CAP:   if (vsRise && phase == 2'd0) nextState = ST_GAP_H;
      ST_GAP_H: nextState = ST_HOST;
      ST_HOST:  if (hostRelease) nextState = ST_GAP_C;
      ST_GAP_C: nextState = ST_ARM;
      default:  nextState = ST_ARM;
    endcase
  end

  // phase 1: setup, phase 2: strobe low, phase 3: hold
  always_comb begin
    if (phase != 2'd0) nextPhase = phase + 2'd1;
    else               nextPhase = startWr ? 2'd1 : 2'd0;
  end

  always_comb begin
    ctrl.clearAddr = (state == ST_ARM) && vsRise;
    ctrl.latchMode = (state == ST_ARM) && vsRise;
    ctrl.loadPix   = startWr;
    ctrl.weLow     = (phase == 2'd1);
    ctrl.advance   = (phase == 2'd3);
  end

  assign capOe      = (state == ST_ARM) || (state == ST_CAP);
  assign hostGrant  = (state == ST_HOST);
  assign frameReady = (state == ST_HOST);

endmodule

// File: rtl/capture_dp.sv
module capture_dp
  import frame_cap_pkg::*;
#(
  parameter int PW         = 8,
  parameter int AW         = 19,
  parameter int MAX_PIXELS = 326688,
  parameter int THRESH     = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  dpCtrl_t       ctrl,
  input  logic [PW-1:0] camPix,
  input  logic          binarize,
  output logic [AW-1:0] sramAddr,
  output logic [PW-1:0] sramData,
  output logic          sramWeN,
  output logic [AW:0]   pixelCount,
  output logic          full
);

  localparam logic [AW:0]   LIMIT  = (AW+1)'(MAX_PIXELS);
  localparam logic [PW-1:0] THR    = PW'(THRESH);
  localparam logic [PW-1:0] PIX_HI = {PW{1'b1}};

  logic [AW:0]   cnt;
  logic [PW-1:0] dataReg;
  logic          weReg;
  logic          modeReg;
  logic [PW-1:0] pixIn;

  assign pixIn = modeReg ? ((camPix >= THR) ? PIX_HI : '0) : camPix;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      dataReg <= '0;
      weReg   <= 1'b1;
      modeReg <= 1'b0;
    end else begin
      if (ctrl.clearAddr)    cnt     <= '0;
      else if (ctrl.advance) cnt     <= cnt + 1'b1;
      if (ctrl.latchMode)    modeReg <= binarize;
      if (ctrl.loadPix)      dataReg <= pixIn;
      weReg <= !ctrl.weLow;
    end
  end

  assign sramAddr   = cnt[AW-1:0];
  assign sramData   = dataReg;
  assign sramWeN    = weReg;
  assign pixelCount = cnt;
  assign full       = (cnt >= LIMIT);

endmodule

// File: rtl/frame_capture_sram.sv
module frame_capture_sram
  import frame_cap_pkg::*;
#(
  parameter int PW         = 8,
  parameter int AW         = 19,
  parameter int MAX_PIXELS = 326688,
  parameter int THRESH     = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          camPclk,
  input  logic          camHref,
  input  logic          camVsync,
  input  logic [PW-1:0] camPix,
  input  logic          binarize,
  input  logic          hostRelease,
  output logic [AW-1:0] sramAddr,
  output logic [PW-1:0] sramData,
  output logic          sramWeN,
  output logic          capOe,
  output logic          hostGrant,
  output logic          frameReady,
  output logic [AW:0]   pixelCount
);

  dpCtrl_t ctrl;
  logic    full;

  capture_ctrl uCtrl (
    .clk         (clk),
    .rst         (rst),
    .camPclk     (camPclk),
    .camHref     (camHref),
    .camVsync    (camVsync),
    .hostRelease (hostRelease),
    .full        (full),
    .ctrl        (ctrl),
    .capOe       (capOe),
    .hostGrant   (hostGrant),
    .frameReady  (frameReady)
  );

  capture_dp #(
    .PW         (PW),
    .AW         (AW),
    .MAX_PIXELS (MAX_PIXELS),
    .THRESH     (THRESH)
  ) uDp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .camPix     (camPix),
    .binarize   (binarize),
    .sramAddr   (sramAddr),
    .sramData   (sramData),
    .sramWeN    (sramWeN),
    .pixelCount (pixelCount),
    .full       (full)
  );

endmodule

// File: rtl/frame_capture_sram_chk.sv
module frame_capture_sram_chk #(
  parameter int PW         = 8,
  parameter int AW         = 19,
  parameter int MAX_PIXELS = 326688
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] sramAddr,
  input logic [PW-1:0] sramData,
  input logic          sramWeN,
  input logic          capOe,
  input logic          hostGrant,
  input logic [AW:0]   pixelCount
);

  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (rst)
    !(capOe && hostGrant));

  // R6
  we_owned_chk: assert property (@(posedge clk) disable iff (rst)
    !sramWeN |-> capOe);

  // R4
  we_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sramWeN) |-> ($stable(sramAddr) && $stable(sramData)));

  // R4
  we_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sramWeN) |-> ($stable(sramAddr) && $stable(sramData)));

  // R5
  gap_to_host_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hostGrant) |-> $past(!capOe));

  // R8
  gap_to_cap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(capOe) |-> $past(!hostGrant));

  // R10
  count_limit_chk: assert property (@(posedge clk) disable iff (rst)
    pixelCount <= (AW+1)'(MAX_PIXELS));

endmodule

bind frame_capture_sram frame_capture_sram_chk #(
  .PW(PW), .AW(AW), .MAX_PIXELS(MAX_PIXELS)
) uChk (
  .clk        (clk),
  .rst        (rst),
  .sramAddr   (sramAddr),
  .sramData   (sramData),
  .sramWeN    (sramWeN),
  .capOe      (capOe),
  .hostGrant  (hostGrant),
  .pixelCount (pixelCount)
);

// File: tb/tb_frame_capture_sram.sv
module tb_frame_capture_sram;

  localparam int PW     = 8;
  localparam int AW     = 19;
  localparam int MAXPIX = 40;
  localparam int THR    = 128;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          camPclk = 1'b0, camHref = 1'b0, camVsync = 1'b0;
  logic [PW-1:0] camPix = '0;
  logic          binarize = 1'b0, hostRelease = 1'b0;
  logic [AW-1:0] sramAddr;
  logic [PW-1:0] sramData;
  logic          sramWeN, capOe, hostGrant, frameReady;
  logic [AW:0]   pixelCount;

  frame_capture_sram #(.PW(PW), .AW(AW), .MAX_PIXELS(MAXPIX), .THRESH(THR)) dut (
    .clk(clk), .rst(rst), .camPclk(camPclk), .camHref(camHref), .camVsync(camVsync),
    .camPix(camPix), .binarize(binarize), .hostRelease(hostRelease),
    .sramAddr(sramAddr), .sramData(sramData), .sramWeN(sramWeN), .capOe(capOe),
    .hostGrant(hostGrant), .frameReady(frameReady), .pixelCount(pixelCount)
  );

  always #10 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // reference model
  int expAddr[$];
  int expData[$];
  int modelSt = 0;     // 0 armed, 1 capturing, 2 host owns
  int stored  = 0;
  bit modelMode = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-clock monitor
  bit          prevWe = 1, prevCap = 1, prevHost = 0;
  logic [AW-1:0] prevAddr = '0;
  logic [PW-1:0] prevData = '0;
  int          lowLen = 0;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(!(capOe && hostGrant), "R6 contention", int'(capOe), 0);
      if (!sramWeN) check(capOe, "R6 strobe without ownership", int'(capOe), 1);
      if (!sramWeN && prevWe) begin
        check(prevAddr == sramAddr && prevData == sramData, "R4 setup",
              int'(sramAddr), int'(prevAddr));
        if (expAddr.size() == 0) begin
          check(0, "R3/R8 unexpected write addr", int'(sramAddr), -1);
        end else begin
          int ea, ed;
          ea = expAddr.pop_front();
          ed = expData.pop_front();
          check(int'(sramAddr) == ea, "R2/R10 write address", int'(sramAddr), ea);
          check(int'(sramData) == ed, "R9 write data", int'(sramData), ed);
        end
      end
      if (!sramWeN) lowLen++;
      if (sramWeN && !prevWe) begin
        check(prevAddr == sramAddr && prevData == sramData, "R4 hold",
              int'(sramData), int'(prevData));
        check(lowLen == 1, "R4 strobe width", lowLen, 1);
        lowLen = 0;
      end
      if (hostGrant && !prevHost) check(!prevCap, "R5 idle gap", int'(prevCap), 0);
      if (capOe && !prevCap) check(!prevHost, "R8 idle gap", int'(prevHost), 0);
      prevWe   = sramWeN;
      prevCap  = capOe;
      prevHost = hostGrant;
      prevAddr = sramAddr;
      prevData = sramData;
    end
  end

  task automatic pclkTick(input bit hr, input logic [PW-1:0] px);
    @(negedge clk);
    camHref = hr;
    camPix  = px;
    camPclk = 1'b0;
    if (modelSt == 1 && hr && stored < MAXPIX) begin
      expAddr.push_back(stored);
      expData.push_back(modelMode ? ((px >= PW'(THR)) ? 255 : 0) : int'(px));
      stored++;
    end
    repeat (4) @(negedge clk);
    camPclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic vsyncPulse();
    @(negedge clk);
    camHref = 1'b0;
    camVsync = 1'b1;
    if (modelSt == 0) begin
      modelSt = 1;
      stored = 0;
      modelMode = binarize;
    end else if (modelSt == 1) begin
      modelSt = 2;
    end
    repeat (3) pclkTick(1'b0, '0);
    camVsync = 1'b0;
    repeat (2) pclkTick(1'b0, '0);
  endtask

  function automatic logic [PW-1:0] genPix(input int f, input int i);
    return PW'((f * 53 + i * 29 + 7) & 255);
  endfunction

  task automatic sendLine(input int f, input int base, input int n);
    for (int i = 0; i < n; i++) pclkTick(1'b1, genPix(f, base + i));
    repeat (2) pclkTick(1'b0, '0);
  endtask

  task automatic frameDone(input string tag, input int expCount);
    @(negedge clk);
    check(frameReady, {"R5 ready ", tag}, int'(frameReady), 1);
    check(hostGrant, {"R5 grant ", tag}, int'(hostGrant), 1);
    check(!capOe, {"R5 capture off ", tag}, int'(capOe), 0);
    check(int'(pixelCount) == expCount, {"R7 count ", tag}, int'(pixelCount), expCount);
    check(expAddr.size() == 0, {"R2 all pixels written ", tag}, expAddr.size(), 0);
  endtask

  task automatic releaseBus();
    @(negedge clk);
    hostRelease = 1'b1;
    @(negedge clk);
    hostRelease = 1'b0;
    check(!hostGrant && !capOe, "R8 gap after release", int'(hostGrant) + int'(capOe), 0);
    check(!frameReady, "R8 ready cleared", int'(frameReady), 0);
    @(negedge clk);
    check(capOe, "R8 capture regains bus", int'(capOe), 1);
    modelSt = 0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(capOe && !hostGrant && !frameReady, "R1 ownership", int'(capOe), 1);
    check(sramWeN, "R1 strobe idle", int'(sramWeN), 1);
    check(pixelCount == 0, "R1 count", int'(pixelCount), 0);

    // R2: pixels before any frame sync are not written
    sendLine(9, 0, 4);

    // frame 1: raw, 3 lines of 6
    binarize = 1'b0;
    vsyncPulse();
    for (int l = 0; l < 3; l++) sendLine(1, l * 6, 6);
    vsyncPulse();
    frameDone("frame1", 18);

    // R8: sync and pixels while host owns
    vsyncPulse();
    sendLine(2, 0, 5);
    check(frameReady && hostGrant, "R8 host keeps bus", int'(hostGrant), 1);
    check(int'(pixelCount) == 18, "R8 count unchanged", int'(pixelCount), 18);
    releaseBus();
    // R8: no fresh sync edge -> no writes
    sendLine(3, 0, 4);

    // frame 2: binarised, mode flipped mid frame (R9)
    binarize = 1'b1;
    vsyncPulse();
    pclkTick(1'b1, 8'd127);
    pclkTick(1'b1, 8'd128);
    pclkTick(1'b1, 8'd0);
    pclkTick(1'b1, 8'd255);
    sendLine(4, 0, 3);
    binarize = 1'b0;
    sendLine(4, 3, 7);
    vsyncPulse();
    frameDone("frame2", 14);
    releaseBus();

    // frame 3: overflow (R10)
    vsyncPulse();
    for (int l = 0; l < 6; l++) sendLine(5, l * 8, 8);
    vsyncPulse();
    frameDone("frame3 R10", MAXPIX);
    releaseBus();

    // frame 4: short frame (R7)
    vsyncPulse();
    sendLine(6, 0, 3);
    vsyncPulse();
    frameDone("frame4 short", 3);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule